// File: doc/BRIEF.md
# Sensor Sample Trigger and Status Unit

This block is the control core of a sampled angle sensor. It decides when a new conversion of the three Hall channels starts. A start comes either from an edge on a dedicated sample pin, or from the rising edge of the serial chip-select that ends a command frame. The frame path can be turned off as a whole, and any single frame can carry a suppress bit that skips its sample. A down-counter stands in for the converter, and a busy indication covers the whole conversion.

When a conversion ends, the unit compares the three channel magnitudes with two thresholds. It latches an underflow flag, set when every channel is weak, and an overflow flag, set when any channel is near full scale. It then raises a conversion-complete level. An interrupt output combines that level with an incoming interrupt, using either AND or OR. Four configuration bits are written through a simple write strobe: sample-pin polarity, frame-sampling disable, interrupt mode and low-power mode. The 8-bit status word is always visible on a port.

The controller has three states. `ST_IDLE` is the state after reset, with no result yet. `ST_CONV` means a conversion is running. `ST_DONE` means a result is held. The transitions are:
- IDLE→CONV on a trigger.
- CONV→CONV while the counter is non-zero.
- CONV→DONE when the counter reaches zero.
- DONE→CONV on a trigger.

A trigger that arrives in `ST_CONV` has no effect.

Top module: `smp_sense_ctl`

## Requirements
- R1: After reset, status reads 0x00. With interrupt mode AND and no completed conversion, irq_out is 0 even when irq_in is 1.
- R2: cfg_wdata[0] selects the sample-pin edge that starts a conversion: 0 selects falling, 1 selects rising. The pin passes through two synchronizing flip-flops, so status bit 0 (busy) reads 1 three clock edges after the active edge is driven. Any other pin change starts nothing.
- R3: A low-to-high transition of cs_n starts a conversion, and busy reads 1 after the next clock edge. This happens only while cfg_wdata[1] (frame-sampling disable) is 0.
- R4: If cmd_suppress is 1 in the cycle where cs_n rises, no conversion starts, and the status word keeps its previous value.
- R5: Busy stays 1 for exactly 32 cycles when cfg_wdata[3] (low power) is 0, and for exactly 8 cycles when it is 1.
- R6: A trigger that arrives while busy is 1 is ignored. The running conversion ends at its original time.
- R7: Status bit 2 (underflow) is 1 after a conversion only if all three channel magnitudes were below 256.
- R8: Status bit 1 (overflow) is 1 after a conversion if any channel magnitude was above 506.
- R9: Status bits 7:3 always read 0. While busy is 0, bits 2:1 hold the result of the most recent conversion and do not change.
- R10: cfg_wdata[2] selects the interrupt mode. With 0, irq_out = irq_in AND complete; with 1, irq_out = irq_in OR complete. Complete is 1 after a conversion ends and 0 from the start of the next one.
- R11: cfg_we loads all four configuration bits at once. After reset all four bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_pin | input | 1 | Asynchronous sample request pin |
| cs_n | input | 1 | Serial chip-select, synchronous to clk |
| cmd_suppress | input | 1 | Suppress bit of the frame ending this cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | {low power, irq OR mode, frame-sampling disable, pin rising edge} |
| mag_a | input | 10 | Magnitude of Hall channel A |
| mag_b | input | 10 | Magnitude of Hall channel B |
| mag_c | input | 10 | Magnitude of Hall channel C |
| irq_in | input | 1 | Incoming interrupt |
| irq_out | output | 1 | Merged interrupt output |
| status | output | 8 | {5'b0, underflow, overflow, busy} |

## Verification
The assertions assume the following about the inputs:
- cs_n is already synchronous to clk.
- The channel magnitudes are treated as sampled on the last cycle of a conversion, so the flags are judged only against values held steady through it.
- The interrupt input may change at any cycle, and the interrupt checks hold combinationally in every cycle.

The stimulus meets these assumptions. It drives all inputs half a cycle away from the sampling edge. It holds the magnitudes fixed from before each trigger until after busy falls. It draws magnitudes from the threshold neighbours 255, 256, 506 and 507 as well as from random values.

// File: rtl/smp_pkg.sv
package smp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_DONE = 2'd2
    } conv_state_e;

    // field order matches the write-data bit positions
    typedef struct packed {
        logic lpwr;
        logic irq_or;
        logic spi_off;
        logic pin_rise;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/smp_cfg_regs.sv
module smp_cfg_regs
    import smp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= cfg_t'(wdata);
        end
    end

endmodule

// File: rtl/smp_trig_detect.sv
module smp_trig_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pin_rise,
    input  logic cs_n,
    input  logic suppress,
    input  logic spi_off,
    output logic trig
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;
    logic               cs_q;
    logic               pin_now;
    logic               pin_old;
    logic               pin_edge;
    logic               cs_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            cs_q  <= 1'b1;
        end else begin
            chain <= {chain[CHAIN_W-2:0], pin};
            cs_q  <= cs_n;
        end
    end

    assign pin_now = chain[SYNC_STAGES-1];
    assign pin_old = chain[SYNC_STAGES];

    always_comb begin
        if (pin_rise) begin
            pin_edge = pin_now & ~pin_old;
        end else begin
            pin_edge = ~pin_now & pin_old;
        end
    end

    assign cs_rise = cs_n & ~cs_q;
    assign trig    = pin_edge | (cs_rise & ~spi_off & ~suppress);

endmodule

// File: rtl/smp_mag_class.sv
module smp_mag_class #(
    parameter int NCH    = 3,
    parameter int CH_W   = 10,
    parameter int UF_LIM = 256,
    parameter int OF_LIM = 506
) (
    input  logic [NCH-1:0][CH_W-1:0] mag,
    output logic                     uflo,
    output logic                     oflo
);

    logic [NCH-1:0] low_v;
    logic [NCH-1:0] high_v;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign low_v[i]  = (mag[i] < CH_W'(UF_LIM));
        assign high_v[i] = (mag[i] > CH_W'(OF_LIM));
    end

    assign uflo = &low_v;
    assign oflo = |high_v;

endmodule

// File: rtl/smp_conv_fsm.sv
module smp_conv_fsm
    import smp_pkg::*;
#(
    parameter int LEN_NORM = 32,
    parameter int LEN_LP   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic lpwr,
    input  logic uflo_in,
    input  logic oflo_in,
    output logic busy,
    output logic done,
    output logic uflo_q,
    output logic oflo_q
);

    localparam int CNT_W = $clog2(LEN_NORM);

    conv_state_e      state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             last;
    logic             uf_nx, of_nx;

    assign last = (cnt == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            uflo_q <= 1'b0;
            oflo_q <= 1'b0;
        end else begin
            state  <= state_nx;
            cnt    <= cnt_nx;
            uflo_q <= uf_nx;
            oflo_q <= of_nx;
        end
    end

    // next state, counter and result latch
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        uf_nx    = uflo_q;
        of_nx    = oflo_q;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (trig) begin
                    state_nx = ST_CONV;
                    cnt_nx   = lpwr ? CNT_W'(LEN_LP - 1) : CNT_W'(LEN_NORM - 1);
                end
            end
            ST_CONV: begin
                if (last) begin
                    state_nx = ST_DONE;
                    uf_nx    = uflo_in;
                    of_nx    = oflo_in;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_CONV: busy = 1'b1;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/smp_sense_ctl.sv
module smp_sense_ctl
    import smp_pkg::*;
#(
    parameter int CH_W        = 10,
    parameter int UF_LIM      = 256,
    parameter int OF_LIM      = 506,
    parameter int LEN_NORM    = 32,
    parameter int LEN_LP      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_pin,
    input  logic            cs_n,
    input  logic            cmd_suppress,
    input  logic            cfg_we,
    input  logic [3:0]      cfg_wdata,
    input  logic [CH_W-1:0] mag_a,
    input  logic [CH_W-1:0] mag_b,
    input  logic [CH_W-1:0] mag_c,
    input  logic            irq_in,
    output logic            irq_out,
    output logic [7:0]      status
);

    localparam int NCH = 3;

    cfg_t                      cfg_q;
    logic                      cfg_imod;
    logic                      trig_any;
    logic                      busy, done;
    logic                      uf_now, of_now;
    logic                      uf_q, of_q;
    logic [NCH-1:0][CH_W-1:0]  mag_v;

    assign mag_v    = {mag_c, mag_b, mag_a};
    assign cfg_imod = cfg_q.irq_or;

    smp_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    smp_trig_detect #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (smp_pin),
        .pin_rise (cfg_q.pin_rise),
        .cs_n     (cs_n),
        .suppress (cmd_suppress),
        .spi_off  (cfg_q.spi_off),
        .trig     (trig_any)
    );

    smp_mag_class #(
        .NCH(NCH), .CH_W(CH_W), .UF_LIM(UF_LIM), .OF_LIM(OF_LIM)
    ) u_class (
        .mag  (mag_v),
        .uflo (uf_now),
        .oflo (of_now)
    );

    smp_conv_fsm #(.LEN_NORM(LEN_NORM), .LEN_LP(LEN_LP)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (trig_any),
        .lpwr    (cfg_q.lpwr),
        .uflo_in (uf_now),
        .oflo_in (of_now),
        .busy    (busy),
        .done    (done),
        .uflo_q  (uf_q),
        .oflo_q  (of_q)
    );

    assign status  = {5'b0, uf_q, of_q, busy};
    assign irq_out = cfg_imod ? (irq_in | done) : (irq_in & done);

endmodule

// File: rtl/smp_sense_chk.sv
module smp_sense_chk #(
    parameter int LEN_NORM = 32,
    parameter int LEN_LP   = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] status,
    input logic       irq_in,
    input logic       irq_out,
    input logic       imod,
    input logic       trig
);

    logic       busy_d;
    int unsigned run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_d <= 1'b0;
            run    <= 0;
        end else begin
            busy_d <= status[0];
            run    <= status[0] ? run + 1 : 0;
        end
    end

    AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:3] == 5'b0);                                              // R9

    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[0] && busy_d == 1'b0) |-> $stable(status[2:1]));          // R9

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !status[0] |-> !(status[2] && status[1]));                         // R7

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |-> (run < LEN_NORM));                                   // R5

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_d && !status[0]) |-> (run == LEN_NORM || run == LEN_LP));    // R5

    AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(trig));                                 // R6

    AST_IRQ_AND_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!imod && !irq_in) |-> !irq_out);                                  // R10

    AST_IRQ_OR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (imod && irq_in) |-> irq_out);                                     // R10

    AST_IRQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |-> (irq_out == (imod && irq_in)));                      // R10

endmodule

bind smp_sense_ctl smp_sense_chk #(.LEN_NORM(LEN_NORM), .LEN_LP(LEN_LP)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .status  (status),
    .irq_in  (irq_in),
    .irq_out (irq_out),
    .imod    (cfg_imod),
    .trig    (trig_any)
);

// File: tb/tb_smp_sense_ctl.sv
module tb_smp_sense_ctl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       smp_pin;
    logic       cs_n;
    logic       cmd_suppress;
    logic       cfg_we;
    logic [3:0] cfg_wdata;
    logic [9:0] mag_a, mag_b, mag_c;
    logic       irq_in;
    logic       irq_out;
    logic [7:0] status;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    smp_sense_ctl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_pin      (smp_pin),
        .cs_n         (cs_n),
        .cmd_suppress (cmd_suppress),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .mag_a        (mag_a),
        .mag_b        (mag_b),
        .mag_c        (mag_c),
        .irq_in       (irq_in),
        .irq_out      (irq_out),
        .status       (status)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_uf(input int a, input int b, input int c);
        return (a < 256) && (b < 256) && (c < 256);
    endfunction

    function automatic bit exp_of(input int a, input int b, input int c);
        return (a > 506) || (b > 506) || (c > 506);
    endfunction

    function automatic logic [9:0] pick_mag();
        case ($urandom % 8)
            0: return 10'd255;
            1: return 10'd256;
            2: return 10'd506;
            3: return 10'd507;
            4: return 10'd0;
            5: return 10'd1023;
            default: return 10'($urandom % 1024);
        endcase
    endfunction

    task automatic write_cfg(input bit pol, input bit smod, input bit imod, input bit lp);
        cfg_wdata = {lp, imod, smod, pol};
        cfg_we    = 1'b1;
        step();
        cfg_we    = 1'b0;
    endtask

    task automatic cs_frame(input bit sup);
        cs_n = 1'b0;
        step();
        cs_n         = 1'b1;
        cmd_suppress = sup;
        step();
        cmd_suppress = 1'b0;
    endtask

    task automatic run_txn(input bit use_pin, input bit pol, input bit smod,
                           input bit imod, input bit lp, input bit skip_cfg);
        logic [7:0] prev;
        int         len;
        bit         euf, eof;
        len = lp ? 8 : 32;
        if (!skip_cfg) write_cfg(pol, smod, imod, lp);
        mag_a  = pick_mag();
        mag_b  = pick_mag();
        mag_c  = pick_mag();
        irq_in = 1'($urandom % 2);
        euf = exp_uf(int'(mag_a), int'(mag_b), int'(mag_c));
        eof = exp_of(int'(mag_a), int'(mag_b), int'(mag_c));
        prev = status;

        if (use_pin) begin
            if (smod) begin
                cs_frame(1'b0);
                chk(status[0] == 1'b0, "R3 frame blocked by disable bit", status[0], 0);
                step();
                chk(status == prev, "R3 status unchanged", status, prev);
            end
            smp_pin = ~pol;
            repeat (4) step();
            chk(status[0] == 1'b0, "R2 inactive edge ignored", status[0], 0);
            chk(status == prev, "R2 status unchanged", status, prev);
            smp_pin = pol;
            step();
            step();
            chk(status[0] == 1'b0, "R2 sync latency", status[0], 0);
            step();
            chk(status[0] == 1'b1, "R2 busy after active edge", status[0], 1);
        end else begin
            cs_frame(1'b1);
            chk(status[0] == 1'b0, "R4 suppressed frame", status[0], 0);
            step();
            chk(status == prev, "R4 status kept", status, prev);
            cs_frame(1'b0);
            chk(status[0] == 1'b1, "R3 busy after frame end", status[0], 1);
        end
        chk(irq_out == (imod & irq_in), "R10 complete cleared at start", irq_out, imod & irq_in);

        for (int k = 1; k < len; k++) begin
            step();
            if (k == 2) cs_n = 1'b0;
            if (k == 3) cs_n = 1'b1;
        end
        chk(status[0] == 1'b1, "R5 busy through last cycle", status[0], 1);
        step();
        chk(status[0] == 1'b0, "R5/R6 busy ends on time", status[0], 0);
        chk(status[2] == euf, "R7 underflow flag", status[2], euf);
        chk(status[1] == eof, "R8 overflow flag", status[1], eof);
        chk(status[7:3] == 5'b0, "R9 upper bits zero", status[7:3], 0);
        chk(irq_out == (imod ? 1'b1 : irq_in), "R10 irq merge after done",
            irq_out, imod ? 1 : irq_in);
        irq_in = ~irq_in;
        #1;
        chk(irq_out == (imod ? 1'b1 : irq_in), "R10 irq merge toggled",
            irq_out, imod ? 1 : irq_in);
        step();
        chk(status[2:1] == {euf, eof}, "R9 flags held", status[2:1], {euf, eof});
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n        = 1'b0;
        smp_pin      = 1'b0;
        cs_n         = 1'b1;
        cmd_suppress = 1'b0;
        cfg_we       = 1'b0;
        cfg_wdata    = '0;
        mag_a = '0; mag_b = '0; mag_c = '0;
        irq_in = 1'b1;
        @(negedge clk);
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk(status == 8'h00, "R1 reset status", status, 0);
        chk(irq_out == 1'b0, "R1 reset irq AND mode", irq_out, 0);

        // defaults: frame sampling on, normal length, AND mode
        run_txn(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);                      // R11

        // directed corners
        run_txn(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        run_txn(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        run_txn(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);

        for (int t = 0; t < 60; t++) begin
            bit up;
            up = 1'($urandom % 2);
            run_txn(up, 1'($urandom % 2), up ? 1'($urandom % 2) : 1'b0,
                    1'($urandom % 2), 1'($urandom % 2), 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule